// File: doc/BRIEF.md
# I2C Controller Flag and Interrupt Status Register

This block keeps the sticky status flags of an I2C/SMBus controller. The protocol engine reports single-cycle event pulses: transmit buffer drained, transmit data wanted, byte received, own address matched, NACK seen, STOP seen, byte count reached, misplaced START or STOP, arbitration lost, overrun, PEC mismatch, timeout, alert falling edge, and START or STOP observed on the bus. The register bus side supplies strobes for a transmit data write, a receive data read, a START or STOP request, a byte count write, a write to the flag-clear register and a write to the status register.

Every flag has its own rule. Some clear when the data register is accessed. Some clear only through the flag-clear register. Two can be set by software. One follows the state of the bus. When the peripheral enable is low, every flag goes to its disabled state. The block drives a 16-bit status word and one interrupt line. The interrupt line is the OR of the flags that have their enable bit set. Serial shifting and bus timing belong to other blocks.

Top module: `i2c_irq_status`

## Requirements
- R1: The status word has these bit positions: 0 TXE, 1 TXIS, 2 RXNE, 3 ADDR, 4 NACKF, 5 STOPF, 6 TC, 7 TCR, 8 BERR, 9 ARLO, 10 OVR, 11 PECERR, 12 TIMEOUT, 13 ALERT, 15 BUSY. Bit 14 always reads 0. Every flag change appears on `status` one clock after the causing input.
- R2: TXE sets on `evt_tx_empty` and clears on `txd_wr`. A status write with bit 0 = 1 sets TXE and raises `tx_flush` in the same cycle.
- R3: TXIS sets on `evt_tx_need` and clears on `txd_wr`. A status write with bit 1 = 1 sets TXIS only when `cfg_no_stretch` is 1. Otherwise the write has no effect.
- R4: RXNE sets on `evt_rx_byte` and clears on `rxd_rd`.
- R5: On `evt_cnt_done`, TC sets if `cfg_reload`=0 and `cfg_autoend`=0. TCR sets if `cfg_reload`=1. With `cfg_reload`=0 and `cfg_autoend`=1, neither flag sets. TC clears on `start_req` or `stop_req`. TCR clears on `cnt_wr` with a non-zero `cnt_val`, and a zero value leaves it set.
- R6: ADDR, NACKF, STOPF, BERR, ARLO, OVR, PECERR, TIMEOUT and ALERT set on their events. Each clears only when `clr_wr` carries a 1 in that flag's status bit position.
- R7: BUSY sets on `evt_start_seen` and clears on `evt_stop_seen`.
- R8: While `periph_en` is 0, and during reset, the status word is 0x0001: only TXE is set.
- R9: ALERT sets only when `cfg_smb_host` and `cfg_alert_en` are both 1. With parameter SMB_EN = 0, bits 11 to 13 read 0.
- R10: When a set and a clear for the same flag arrive in the same cycle, the flag ends set.
- R11: `irq` is 1 exactly when some bit of `status & irq_en` is 1. It follows `irq_en` in the same cycle.
- R12: A status write has no effect on bits other than 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periph_en | input | 1 | Peripheral enable; 0 forces the disabled state |
| cfg_no_stretch | input | 1 | Clock stretching disabled |
| cfg_reload | input | 1 | Byte count reload mode |
| cfg_autoend | input | 1 | Automatic STOP after byte count |
| cfg_smb_host | input | 1 | SMBus host mode |
| cfg_alert_en | input | 1 | Alert detection enabled |
| evt_tx_empty | input | 1 | Transmit data register drained |
| evt_tx_need | input | 1 | Next transmit byte is needed |
| evt_rx_byte | input | 1 | Received byte moved to receive register |
| evt_addr_hit | input | 1 | Own address matched |
| evt_nack | input | 1 | NACK received after a byte |
| evt_stop_own | input | 1 | STOP seen in an own transfer |
| evt_cnt_done | input | 1 | Programmed byte count transferred |
| evt_misplaced | input | 1 | Misplaced START/STOP in own transfer |
| evt_arb_lost | input | 1 | Arbitration lost |
| evt_overrun | input | 1 | Overrun or underrun |
| evt_pec_bad | input | 1 | Received PEC mismatch |
| evt_timeout | input | 1 | Timeout or extended low detected |
| evt_alert_fall | input | 1 | Falling edge on the alert line |
| evt_start_seen | input | 1 | START detected on the bus |
| evt_stop_seen | input | 1 | STOP detected on the bus |
| txd_wr | input | 1 | Transmit data register write |
| rxd_rd | input | 1 | Receive data register read |
| start_req | input | 1 | Software START request |
| stop_req | input | 1 | Software STOP request |
| cnt_wr | input | 1 | Byte count write |
| cnt_val | input | CNT_W | Byte count value written |
| clr_wr | input | 1 | Flag-clear register write |
| clr_data | input | 16 | Flag-clear data, bit-aligned to status |
| stat_wr | input | 1 | Status register write |
| stat_data | input | 16 | Status write data |
| irq_en | input | 16 | Per-flag interrupt enables, bit-aligned to status |
| status | output | 16 | Status word |
| irq | output | 1 | Combined interrupt |
| tx_flush | output | 1 | Pulse to flush the transmit data register |

## Verification
Assertions check four things every cycle. Each flag cell lets a set beat a same-cycle clear and otherwise holds its value. The disabled state is reached one clock after the enable drops. RXNE clears after a read, and neither a blocked software write to TXIS nor an alert edge outside host mode with alert enabled can raise a flag. Some behaviour is visible only in the bench's scenarios. These are the exact bit layout across mixed event patterns, the TC/TCR split across the reload and auto-end settings, and the zero byte-count write that leaves TCR set. They also include the selective clears through the clear register, status writes to unwritable bits, and the interrupt mask tracking `irq_en`.

// File: rtl/i2c_irq_pkg.sv
// Package: bit positions and masks for the I2C flag/status word.
// Assumes a 16-bit status word; the positions are decoded by software.
package i2c_irq_pkg;

    localparam int STAT_W      = 16;

    localparam int BIT_TXE     = 0;
    localparam int BIT_TXIS    = 1;
    localparam int BIT_RXNE    = 2;
    localparam int BIT_ADDR    = 3;
    localparam int BIT_NACK    = 4;
    localparam int BIT_STOP    = 5;
    localparam int BIT_TC      = 6;
    localparam int BIT_TCR     = 7;
    localparam int BIT_BERR    = 8;
    localparam int BIT_ARLO    = 9;
    localparam int BIT_OVR     = 10;
    localparam int BIT_PEC     = 11;
    localparam int BIT_TOUT    = 12;
    localparam int BIT_ALERT   = 13;
    localparam int BIT_RSVD    = 14;
    localparam int BIT_BUSY    = 15;

    typedef logic [STAT_W-1:0] stat_vec_t;

    // Flags that only the flag-clear register can clear
    localparam stat_vec_t CLR_REG_MASK =
        stat_vec_t'((1 << BIT_ADDR) | (1 << BIT_NACK) | (1 << BIT_STOP) |
                    (1 << BIT_BERR) | (1 << BIT_ARLO) | (1 << BIT_OVR)  |
                    (1 << BIT_PEC)  | (1 << BIT_TOUT) | (1 << BIT_ALERT));

    // Value of the status word while disabled or in reset
    localparam stat_vec_t DISABLED_VAL = stat_vec_t'(1 << BIT_TXE);

endpackage

// File: rtl/i2c_irq_rules.sv
// Module: i2c_irq_rules
// Turns the engine events and register strobes into one set vector and one
// clear vector, both aligned to the status bit positions. This module is
// purely combinational. Precedence between set and clear is applied in the
// flag cells.
module i2c_irq_rules
    import i2c_irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             cfg_no_stretch,
    input  logic             cfg_reload,
    input  logic             cfg_autoend,
    input  logic             cfg_smb_host,
    input  logic             cfg_alert_en,
    input  logic             evt_tx_empty,
    input  logic             evt_tx_need,
    input  logic             evt_rx_byte,
    input  logic             evt_addr_hit,
    input  logic             evt_nack,
    input  logic             evt_stop_own,
    input  logic             evt_cnt_done,
    input  logic             evt_misplaced,
    input  logic             evt_arb_lost,
    input  logic             evt_overrun,
    input  logic             evt_pec_bad,
    input  logic             evt_timeout,
    input  logic             evt_alert_fall,
    input  logic             evt_start_seen,
    input  logic             evt_stop_seen,
    input  logic             txd_wr,
    input  logic             rxd_rd,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             clr_wr,
    input  stat_vec_t        clr_data,
    input  logic             stat_wr,
    input  stat_vec_t        stat_data,
    output stat_vec_t        set_vec,
    output stat_vec_t        clr_vec
);

    stat_vec_t sw_req;
    logic      sw_unused;

    // Status write data, gated by the write strobe
    always_comb sw_req = stat_wr ? stat_data : '0;

    // Only bits 0 and 1 of a status write do anything
    assign sw_unused = ^sw_req[STAT_W-1:2];

    // Set sources for each flag
    always_comb begin
        set_vec              = '0;
        set_vec[BIT_TXE]     = evt_tx_empty | sw_req[BIT_TXE];
        set_vec[BIT_TXIS]    = evt_tx_need | (sw_req[BIT_TXIS] & cfg_no_stretch);
        set_vec[BIT_RXNE]    = evt_rx_byte;
        set_vec[BIT_ADDR]    = evt_addr_hit;
        set_vec[BIT_NACK]    = evt_nack;
        set_vec[BIT_STOP]    = evt_stop_own;
        set_vec[BIT_TC]      = evt_cnt_done & ~cfg_reload & ~cfg_autoend;
        set_vec[BIT_TCR]     = evt_cnt_done & cfg_reload;
        set_vec[BIT_BERR]    = evt_misplaced;
        set_vec[BIT_ARLO]    = evt_arb_lost;
        set_vec[BIT_OVR]     = evt_overrun;
        set_vec[BIT_PEC]     = evt_pec_bad;
        set_vec[BIT_TOUT]    = evt_timeout;
        set_vec[BIT_ALERT]   = evt_alert_fall & cfg_smb_host & cfg_alert_en;
        set_vec[BIT_BUSY]    = evt_start_seen;
    end

    // Clear sources: the clear register plus access-driven clears
    always_comb begin
        clr_vec            = clr_wr ? (clr_data & CLR_REG_MASK) : '0;
        clr_vec[BIT_TXE]   = txd_wr;
        clr_vec[BIT_TXIS]  = txd_wr;
        clr_vec[BIT_RXNE]  = rxd_rd;
        clr_vec[BIT_TC]    = start_req | stop_req;
        clr_vec[BIT_TCR]   = cnt_wr & (|cnt_val);
        clr_vec[BIT_BUSY]  = evt_stop_seen;
    end

endmodule

// File: rtl/i2c_irq_flag.sv
// Module: i2c_irq_flag
// Holds one sticky status flag. While disabled or in reset the flag is
// forced to HOLD_VAL. Otherwise a set beats a clear in the same cycle.
// Assumes set and clr are single-cycle, synchronous strobes.
module i2c_irq_flag #(
    parameter logic HOLD_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic set,
    input  logic clr,
    output logic q
);

    // Flag update: disabled hold, then set, then clear
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= HOLD_VAL;
        else if (!enable) q <= HOLD_VAL;
        else if (set)     q <= 1'b1;
        else if (clr)     q <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && set) |=> q);                                   // R10
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (q == HOLD_VAL));                             // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && clr && !set) |=> !q);                          // R6
    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !set && !clr) |=> $stable(q));                 // R1

endmodule

// File: rtl/i2c_irq_combine.sv
// Module: i2c_irq_combine
// Masks the status word with the per-bit enables and reduces it to one
// interrupt line. Combinational; bit positions match the status word.
module i2c_irq_combine
    import i2c_irq_pkg::*;
(
    input  stat_vec_t flags,
    input  stat_vec_t enables,
    output logic      irq
);

    // Any enabled flag raises the interrupt
    always_comb irq = |(flags & enables);

endmodule

// File: rtl/i2c_irq_status.sv
// Module: i2c_irq_status (top)
// The flag and interrupt status register of an I2C/SMBus controller. It
// builds a flag cell for each implemented bit, ties the reserved bit to 0,
// and ties the SMBus-only bits to 0 when SMB_EN is 0. It also drives the
// transmit flush pulse and the combined interrupt. All inputs are assumed
// synchronous to clk.
module i2c_irq_status
    import i2c_irq_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter bit SMB_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             periph_en,
    input  logic             cfg_no_stretch,
    input  logic             cfg_reload,
    input  logic             cfg_autoend,
    input  logic             cfg_smb_host,
    input  logic             cfg_alert_en,
    input  logic             evt_tx_empty,
    input  logic             evt_tx_need,
    input  logic             evt_rx_byte,
    input  logic             evt_addr_hit,
    input  logic             evt_nack,
    input  logic             evt_stop_own,
    input  logic             evt_cnt_done,
    input  logic             evt_misplaced,
    input  logic             evt_arb_lost,
    input  logic             evt_overrun,
    input  logic             evt_pec_bad,
    input  logic             evt_timeout,
    input  logic             evt_alert_fall,
    input  logic             evt_start_seen,
    input  logic             evt_stop_seen,
    input  logic             txd_wr,
    input  logic             rxd_rd,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             clr_wr,
    input  logic [15:0]      clr_data,
    input  logic             stat_wr,
    input  logic [15:0]      stat_data,
    input  logic [15:0]      irq_en,
    output logic [15:0]      status,
    output logic             irq,
    output logic             tx_flush
);

    stat_vec_t set_vec;
    stat_vec_t clr_vec;
    stat_vec_t flags;
    logic      lint_unused;

    i2c_irq_rules #(.CNT_W(CNT_W)) u_rules (
        .cfg_no_stretch (cfg_no_stretch),
        .cfg_reload     (cfg_reload),
        .cfg_autoend    (cfg_autoend),
        .cfg_smb_host   (cfg_smb_host),
        .cfg_alert_en   (cfg_alert_en),
        .evt_tx_empty   (evt_tx_empty),
        .evt_tx_need    (evt_tx_need),
        .evt_rx_byte    (evt_rx_byte),
        .evt_addr_hit   (evt_addr_hit),
        .evt_nack       (evt_nack),
        .evt_stop_own   (evt_stop_own),
        .evt_cnt_done   (evt_cnt_done),
        .evt_misplaced  (evt_misplaced),
        .evt_arb_lost   (evt_arb_lost),
        .evt_overrun    (evt_overrun),
        .evt_pec_bad    (evt_pec_bad),
        .evt_timeout    (evt_timeout),
        .evt_alert_fall (evt_alert_fall),
        .evt_start_seen (evt_start_seen),
        .evt_stop_seen  (evt_stop_seen),
        .txd_wr         (txd_wr),
        .rxd_rd         (rxd_rd),
        .start_req      (start_req),
        .stop_req       (stop_req),
        .cnt_wr         (cnt_wr),
        .cnt_val        (cnt_val),
        .clr_wr         (clr_wr),
        .clr_data       (clr_data),
        .stat_wr        (stat_wr),
        .stat_data      (stat_data),
        .set_vec        (set_vec),
        .clr_vec        (clr_vec)
    );

    // One flag cell per implemented bit; absent bits read 0
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (i == BIT_RSVD ||
            (!SMB_EN && (i == BIT_PEC || i == BIT_TOUT || i == BIT_ALERT))) begin : g_zero
            assign flags[i] = 1'b0;
        end else begin : g_cell
            i2c_irq_flag #(.HOLD_VAL(DISABLED_VAL[i])) u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .enable (periph_en),
                .set    (set_vec[i]),
                .clr    (clr_vec[i]),
                .q      (flags[i])
            );
        end
    end

    // Strobes feeding tied-off bits are intentionally dropped
    assign lint_unused = ^{set_vec[BIT_RSVD], clr_vec[BIT_RSVD],
                           set_vec[BIT_ALERT:BIT_PEC], clr_vec[BIT_ALERT:BIT_PEC]};

    // Status word drive
    assign status = flags;

    // Software flush of the transmit register
    assign tx_flush = periph_en & stat_wr & stat_data[BIT_TXE];

    i2c_irq_combine u_combine (
        .flags   (flags),
        .enables (irq_en),
        .irq     (irq)
    );

    AST_PE_OFF_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_en |=> (status == 16'h0001));                              // R8
    AST_TXIS_SW_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && stat_data[1] && !cfg_no_stretch && !evt_tx_need && !status[1])
        |=> !status[1]);                                                   // R3
    AST_RXNE_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && rxd_rd && !evt_rx_byte) |=> !status[2]);             // R4
    AST_ALERT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((!cfg_smb_host || !cfg_alert_en) && !status[13]) |=> !status[13]); // R9
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && evt_start_seen) |=> status[15]);                     // R7

endmodule

// File: tb/i2c_irq_status_tb.sv
module i2c_irq_status_tb;

    logic clk = 1'b0;
    logic rst_n;
    logic periph_en, cfg_no_stretch, cfg_reload, cfg_autoend, cfg_smb_host, cfg_alert_en;
    logic evt_tx_empty, evt_tx_need, evt_rx_byte, evt_addr_hit, evt_nack, evt_stop_own;
    logic evt_cnt_done, evt_misplaced, evt_arb_lost, evt_overrun, evt_pec_bad, evt_timeout;
    logic evt_alert_fall, evt_start_seen, evt_stop_seen;
    logic txd_wr, rxd_rd, start_req, stop_req, cnt_wr, clr_wr, stat_wr;
    logic [7:0]  cnt_val;
    logic [15:0] clr_data, stat_data, irq_en, status;
    logic irq, tx_flush;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [15:0] st;
        logic        irq;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;   // 100 MHz

    i2c_irq_status u_dut (.*);

    // Drop every single-cycle strobe
    task automatic idle_pulses();
        {evt_tx_empty, evt_tx_need, evt_rx_byte, evt_addr_hit, evt_nack, evt_stop_own,
         evt_cnt_done, evt_misplaced, evt_arb_lost, evt_overrun, evt_pec_bad, evt_timeout,
         evt_alert_fall, evt_start_seen, evt_stop_seen} = '0;
        {txd_wr, rxd_rd, start_req, stop_req, cnt_wr, clr_wr, stat_wr} = '0;
        cnt_val = '0; clr_data = '0; stat_data = '0;
    endtask

    // Driver: push the expected result of the current inputs, advance one cycle
    task automatic step(input logic [15:0] exp, input string tag);
        item_t it;
        it.st  = exp;
        it.irq = |(exp & irq_en);
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        idle_pulses();
    endtask

    // Monitor: compare after each rising edge settles
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (status !== it.st || irq !== it.irq) begin
                    errors++;
                    $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                             it.tag, status, irq, it.st, it.irq);
                end
            end
        end
    end

    task automatic check_flush(input logic exp, input string tag);
        #1;
        checks++;
        if (tx_flush !== exp) begin
            errors++;
            $display("FAIL %s: tx_flush=%b expected %b", tag, tx_flush, exp);
        end
    endtask

    // Watchdog
    initial begin
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; periph_en = 1'b0;
        {cfg_no_stretch, cfg_reload, cfg_autoend, cfg_smb_host, cfg_alert_en} = '0;
        irq_en = '0;
        idle_pulses();
        @(negedge clk);
        step(16'h0001, "R8 reset state");
        rst_n = 1'b1; periph_en = 1'b1;
        step(16'h0001, "R8 enable keeps TXE");
        txd_wr = 1;                         step(16'h0000, "R2 txd write clears TXE");
        evt_tx_empty = 1; evt_tx_need = 1;  step(16'h0003, "R2 R3 empty/need set");
        txd_wr = 1;                         step(16'h0000, "R3 txd write clears TXIS");
        stat_wr = 1; stat_data = 16'h0002;  step(16'h0000, "R3 sw TXIS blocked with stretch");
        cfg_no_stretch = 1;
        stat_wr = 1; stat_data = 16'h0002;  step(16'h0002, "R3 sw TXIS allowed");
        stat_wr = 1; stat_data = 16'h0001;
        check_flush(1'b1, "R2 flush pulse");
        step(16'h0003, "R2 sw TXE flush");
        check_flush(1'b0, "R2 flush idle");
        stat_wr = 1; stat_data = 16'hFFFC;  step(16'h0003, "R12 other bits ignored");
        txd_wr = 1;                         step(16'h0000, "R2 clear both");
        evt_rx_byte = 1;                    step(16'h0004, "R4 RXNE set");
        rxd_rd = 1;                         step(16'h0000, "R4 read clears RXNE");
        evt_cnt_done = 1;                   step(16'h0040, "R5 TC set");
        start_req = 1;                      step(16'h0000, "R5 START clears TC");
        evt_cnt_done = 1;                   step(16'h0040, "R5 TC set again");
        stop_req = 1;                       step(16'h0000, "R5 STOP clears TC");
        cfg_autoend = 1;
        evt_cnt_done = 1;                   step(16'h0000, "R5 autoend sets nothing");
        cfg_autoend = 0; cfg_reload = 1;
        evt_cnt_done = 1;                   step(16'h0080, "R5 TCR set");
        cnt_wr = 1; cnt_val = 8'd0;         step(16'h0080, "R5 zero count keeps TCR");
        cnt_wr = 1; cnt_val = 8'd5;         step(16'h0000, "R5 count write clears TCR");
        {evt_addr_hit, evt_nack, evt_stop_own, evt_misplaced, evt_arb_lost,
         evt_overrun, evt_pec_bad, evt_timeout, evt_alert_fall} = '1;
        step(16'h1F38, "R6 R9 events, alert gated");
        cfg_smb_host = 1; evt_alert_fall = 1; step(16'h1F38, "R9 alert needs enable");
        cfg_alert_en = 1; evt_alert_fall = 1; step(16'h3F38, "R9 alert set");
        clr_wr = 1; clr_data = 16'h0208;    step(16'h3D30, "R6 selective clear");
        evt_nack = 1; clr_wr = 1; clr_data = 16'h0010; step(16'h3D30, "R10 set beats clear");
        clr_wr = 1; clr_data = 16'hFFFF;    step(16'h0000, "R6 clear all");
        irq_en = 16'h0004; evt_rx_byte = 1; step(16'h0004, "R11 irq enabled");
        irq_en = 16'h0008;                  step(16'h0004, "R11 irq masked");
        evt_start_seen = 1;                 step(16'h8004, "R7 BUSY set");
        evt_stop_seen = 1;                  step(16'h0004, "R7 BUSY clear");
        evt_start_seen = 1; evt_stop_seen = 1; step(16'h8004, "R10 BUSY set wins");
        periph_en = 0;                      step(16'h0001, "R8 disable");
        evt_nack = 1; evt_rx_byte = 1;      step(16'h0001, "R8 events ignored while off");
        periph_en = 1;                      step(16'h0001, "R8 re-enable");
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule